// File: doc/BRIEF.md
# Sequenced Colour Lookup Loader

This block is a bus-attached register pair that fills a 256-entry colour lookup table, one 8-bit red, green and blue value per entry. Software first writes the entry number into the index register, then writes colour bytes to the data register. Each data write stores one component. The components follow a fixed order: red, then green, then blue. After blue, the entry number advances by one and wraps from 255 to 0. This lets a whole table be streamed with a single index write.

A display pipeline reads the table through its own port. It presents an entry number and gets the three components back one clock later. Every stored component also raises a one-cycle update strobe. The strobe names the entry and the component, so downstream caches can refresh that entry.

The sequencer has three named states:
- `PH_RED`: the next data write stores red. Transition on a data write: go to `PH_GRN`.
- `PH_GRN`: the next data write stores green. Transition on a data write: go to `PH_BLU`.
- `PH_BLU`: the next data write stores blue. Transition on a data write: go back to `PH_RED` and increment the index.

From any state, an index write goes to `PH_RED`. Any other access leaves the state where it is.

Top module: `pal_dac_regs`

## Requirements
- R1: After reset, every entry reads (0,0,0) except entry 255, which reads (255,255,255). The index is 0 and the state is `PH_RED`, so the first data write stores red of entry 0.
- R2: A full-word write at byte offset 0 loads the index from data bits 31:24 and moves the sequencer to `PH_RED`.
- R3: Full-word writes at byte offset 4 store data bits 31:24. Successive writes store red, then green, then blue of the current entry.
- R4: A blue write increments the index modulo 256 and returns the sequencer to `PH_RED`. In particular, entry 255 is followed by entry 0.
- R5: An index write between components abandons the partial entry. The next data write stores red.
- R6: Bus reads return 0 and change neither the table, the index nor the state.
- R7: Writes to byte offsets other than 0 and 4 are ignored. This includes offsets 8 and 12 and any address with bits 1:0 non-zero.
- R8: A write whose byte enables are not all four set is ignored, at any offset.
- R9: One cycle after each stored component, `upd_valid` is high for one cycle. At the same time, `upd_idx` gives the entry and `upd_comp` gives the component, coded 0 = red, 1 = green, 2 = blue. In every other cycle `upd_valid` is low.
- R10: The display port returns the entry selected by `pix_idx` one cycle after it is presented. If a bus write changes that same entry in the same cycle, the port returns the old value, and the new value one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset within the 16-byte window |
| bus_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| bus_wdata | input | 32 | Write data; bits 31:24 carry the byte used |
| bus_rdata | output | 32 | Read data, always zero |
| pix_idx | input | 8 | Display lookup entry number |
| pix_red | output | 8 | Red of the looked-up entry, one cycle later |
| pix_grn | output | 8 | Green of the looked-up entry, one cycle later |
| pix_blu | output | 8 | Blue of the looked-up entry, one cycle later |
| upd_valid | output | 1 | Component-stored strobe |
| upd_idx | output | 8 | Entry the stored component belongs to |
| upd_comp | output | 2 | Component stored: 0 red, 1 green, 2 blue |

## Verification
The display lookup and a bus write can hit the same entry in the same cycle. Which value the lookup returns then is the hazard of interest. The bench drives `pix_idx` with the entry that the current data write is about to change, at the same clock edge as the write. It expects the pre-write component on that edge and the newly written byte on the next. The random phase also keeps the lookup port busy while writes stream in. Full-table sweeps then compare every entry against the bench's own model of the table.

// File: rtl/pal_pkg.sv
package pal_pkg;

    // Sequencer state: which colour component the next data write stores.
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    localparam int unsigned N_COMP = 3;

endpackage

// File: rtl/pal_bus_decode.sv
module pal_bus_decode #(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned IDX_OFS = 0,
    parameter int unsigned DAT_OFS = 4
) (
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W/8-1:0]   bus_be,
    output logic                  idx_wr,
    output logic                  dat_wr,
    output logic [DATA_W-1:0]     bus_rdata
);
    localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(IDX_OFS);
    localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(DAT_OFS);

    logic full_word;
    logic wr_ok;

    // Only a write with every byte lane enabled is accepted.
    assign full_word = &bus_be;
    assign wr_ok     = bus_valid && bus_write && full_word;
    assign idx_wr    = wr_ok && (bus_addr == IDX_A);
    assign dat_wr    = wr_ok && (bus_addr == DAT_A);

    // Register reads carry no data.
    assign bus_rdata = '0;
endmodule

// File: rtl/pal_seq_fsm.sv
module pal_seq_fsm
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idx_wr,
    input  logic               dat_wr,
    input  logic [IDX_W-1:0]   idx_field,
    output phase_e             cur_ph,
    output logic [IDX_W-1:0]   cur_idx,
    output logic [N_COMP-1:0]  comp_we,
    output logic               upd_valid,
    output logic [IDX_W-1:0]   upd_idx,
    output logic [1:0]         upd_comp
);
    phase_e             nxt_ph;
    logic [IDX_W-1:0]   nxt_idx;

    // State and index register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ph  <= PH_RED;
            cur_idx <= '0;
        end else begin
            cur_ph  <= nxt_ph;
            cur_idx <= nxt_idx;
        end
    end

    // Transitions: an index write restarts the walk; data writes advance it.
    always_comb begin
        nxt_ph  = cur_ph;
        nxt_idx = cur_idx;
        if (idx_wr) begin
            nxt_ph  = PH_RED;
            nxt_idx = idx_field;
        end else if (dat_wr) begin
            unique case (cur_ph)
                PH_RED: nxt_ph = PH_GRN;
                PH_GRN: nxt_ph = PH_BLU;
                PH_BLU: begin
                    nxt_ph  = PH_RED;
                    nxt_idx = cur_idx + 1'b1;
                end
                default: nxt_ph = PH_RED;
            endcase
        end
    end

    // Outputs: one component write enable per state.
    always_comb begin
        comp_we = '0;
        if (dat_wr) begin
            unique case (cur_ph)
                PH_RED:  comp_we[0] = 1'b1;
                PH_GRN:  comp_we[1] = 1'b1;
                PH_BLU:  comp_we[2] = 1'b1;
                default: comp_we    = '0;
            endcase
        end
    end

    // Update strobe, one cycle after the stored component.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            upd_idx   <= '0;
            upd_comp  <= 2'd0;
        end else begin
            upd_valid <= dat_wr;
            if (dat_wr) begin
                upd_idx  <= cur_idx;
                upd_comp <= cur_ph;
            end
        end
    end
endmodule

// File: rtl/pal_color_bank.sv
module pal_color_bank #(
    parameter int unsigned IDX_W   = 8,
    parameter int unsigned ENTRY_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [ENTRY_W-1:0]  wr_val,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [ENTRY_W-1:0]  rd_val
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [ENTRY_W-1:0] mem [DEPTH];

    // Reset image: all zero, the last entry at full scale.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= (i == DEPTH - 1) ? {ENTRY_W{1'b1}} : '0;
            end
        end else if (we) begin
            mem[wr_idx] <= wr_val;
        end
    end

    // Registered lookup: samples the array before this edge's write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_val <= '0;
        end else begin
            rd_val <= mem[rd_idx];
        end
    end
endmodule

// File: rtl/pal_dac_regs.sv
module pal_dac_regs
    import pal_pkg::*;
#(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned IDX_W   = 8,
    parameter int unsigned ENTRY_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W/8-1:0]  bus_be,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [IDX_W-1:0]     pix_idx,
    output logic [ENTRY_W-1:0]   pix_red,
    output logic [ENTRY_W-1:0]   pix_grn,
    output logic [ENTRY_W-1:0]   pix_blu,
    output logic                 upd_valid,
    output logic [IDX_W-1:0]     upd_idx,
    output logic [1:0]           upd_comp
);
    logic                                idx_wr;
    logic                                dat_wr;
    logic [N_COMP-1:0]                   comp_we;
    logic [IDX_W-1:0]                    cur_idx;
    phase_e                              cur_ph;
    logic [N_COMP-1:0][ENTRY_W-1:0]      comp_out;
    logic [ENTRY_W-1:0]                  comp_byte;
    logic [IDX_W-1:0]                    idx_field;
    logic                                unused_low;

    // Both registers take their payload from the top of the data word.
    assign comp_byte  = bus_wdata[DATA_W-1 -: ENTRY_W];
    assign idx_field  = bus_wdata[DATA_W-1 -: IDX_W];
    assign unused_low = ^bus_wdata[DATA_W-ENTRY_W-1:0];

    pal_bus_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .idx_wr    (idx_wr),
        .dat_wr    (dat_wr),
        .bus_rdata (bus_rdata)
    );

    pal_seq_fsm #(
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (idx_wr),
        .dat_wr    (dat_wr),
        .idx_field (idx_field),
        .cur_ph    (cur_ph),
        .cur_idx   (cur_idx),
        .comp_we   (comp_we),
        .upd_valid (upd_valid),
        .upd_idx   (upd_idx),
        .upd_comp  (upd_comp)
    );

    for (genvar c = 0; c < N_COMP; c++) begin : g_bank
        pal_color_bank #(
            .IDX_W   (IDX_W),
            .ENTRY_W (ENTRY_W)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (comp_we[c]),
            .wr_idx (cur_idx),
            .wr_val (comp_byte),
            .rd_idx (pix_idx),
            .rd_val (comp_out[c])
        );
    end

    assign pix_red = comp_out[0];
    assign pix_grn = comp_out[1];
    assign pix_blu = comp_out[2];
endmodule

// File: rtl/pal_dac_regs_chk.sv
module pal_dac_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [3:0]  bus_addr,
    input logic [3:0]  bus_be,
    input logic [31:0] bus_wdata,
    input logic        upd_valid,
    input logic [7:0]  upd_idx,
    input logic [1:0]  upd_comp,
    input logic [1:0]  cur_ph,
    input logic [7:0]  cur_idx
);
    logic full_wr;
    logic dat_acc;
    logic idx_acc;

    assign full_wr = bus_valid && bus_write && (bus_be == 4'hF);
    assign dat_acc = full_wr && (bus_addr == 4'd4);
    assign idx_acc = full_wr && (bus_addr == 4'd0);

    p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_acc |=> (cur_ph == 2'd0) && (cur_idx == $past(bus_wdata[31:24])));

    p_red_to_green_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_acc && cur_ph == 2'd0) |=> (cur_ph == 2'd1) && (upd_comp == 2'd0));

    p_green_to_blue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_acc && cur_ph == 2'd1) |=> (cur_ph == 2'd2) && (upd_comp == 2'd1));

    p_legal_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cur_ph != 2'd3);

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_acc && cur_ph == 2'd2) |=> (cur_ph == 2'd0) && (cur_idx == $past(cur_idx) + 8'd1));

    p_read_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> !upd_valid && $stable(cur_idx) && $stable(cur_ph));

    p_bad_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full_wr && bus_addr != 4'd0 && bus_addr != 4'd4) |=> !upd_valid && $stable(cur_idx) && $stable(cur_ph));

    p_partial_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_be != 4'hF) |=> !upd_valid && $stable(cur_idx) && $stable(cur_ph));

    p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dat_acc |=> upd_valid && (upd_idx == $past(cur_idx)));

    p_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_acc |=> !upd_valid);
endmodule

bind pal_dac_regs pal_dac_regs_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .upd_valid (upd_valid),
    .upd_idx   (upd_idx),
    .upd_comp  (upd_comp),
    .cur_ph    (u_fsm.cur_ph),
    .cur_idx   (u_fsm.cur_idx)
);

// File: tb/test_pal_dac_regs.sv
`timescale 1ns/100ps
module test_pal_dac_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_idx = '0;
    logic [7:0]  pix_red, pix_grn, pix_blu;
    logic        upd_valid;
    logic [7:0]  upd_idx;
    logic [1:0]  upd_comp;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_r [256];
    logic [7:0] m_g [256];
    logic [7:0] m_b [256];
    logic [7:0] m_idx;
    logic [1:0] m_ph;

    always #2.5 clk = ~clk;

    pal_dac_regs i_pal_dac_regs (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pix_idx(pix_idx), .pix_red(pix_red),
        .pix_grn(pix_grn), .pix_blu(pix_blu), .upd_valid(upd_valid),
        .upd_idx(upd_idx), .upd_comp(upd_comp)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 256; i++) begin
            m_r[i] = (i == 255) ? 8'hFF : 8'h00;
            m_g[i] = (i == 255) ? 8'hFF : 8'h00;
            m_b[i] = (i == 255) ? 8'hFF : 8'h00;
        end
        m_idx = 8'd0;
        m_ph  = 2'd0;
    endfunction

    // Returns 1 when the access stores a component; updates the model.
    function automatic bit model_apply(input logic wr, input logic [3:0] a,
                                       input logic [31:0] d, input logic [3:0] be,
                                       output logic [7:0] e_idx, output logic [1:0] e_comp);
        e_idx  = m_idx;
        e_comp = m_ph;
        if (!wr || be != 4'hF) return 1'b0;
        if (a == 4'd0) begin
            m_idx = d[31:24];
            m_ph  = 2'd0;
            return 1'b0;
        end
        if (a != 4'd4) return 1'b0;
        case (m_ph)
            2'd0: begin m_r[m_idx] = d[31:24]; m_ph = 2'd1; end
            2'd1: begin m_g[m_idx] = d[31:24]; m_ph = 2'd2; end
            default: begin m_b[m_idx] = d[31:24]; m_ph = 2'd0; m_idx = m_idx + 8'd1; end
        endcase
        return 1'b1;
    endfunction

    task automatic access(input logic wr, input logic [3:0] a, input logic [31:0] d,
                          input logic [3:0] be, input string req);
        logic [7:0] e_idx;
        logic [1:0] e_comp;
        bit         e_upd;
        e_upd = model_apply(wr, a, d, be, e_idx, e_comp);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d; bus_be = be;
        #1;
        if (!wr) check(bus_rdata == 32'd0, "R6", "read data", bus_rdata, 32'd0);
        @(posedge clk);
        #1;
        bus_valid = 1'b0;
        check(upd_valid == e_upd, req, "upd_valid", {31'd0, upd_valid}, {31'd0, e_upd});
        if (e_upd) begin
            check(upd_idx == e_idx, req, "upd_idx", {24'd0, upd_idx}, {24'd0, e_idx});
            check(upd_comp == e_comp, req, "upd_comp", {30'd0, upd_comp}, {30'd0, e_comp});
        end
    endtask

    task automatic sweep(input string req);
        int bad = 0;
        logic [23:0] first_act = '0, first_exp = '0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            pix_idx = 8'(i);
            @(posedge clk);
            #1;
            if ({pix_red, pix_grn, pix_blu} != {m_r[i], m_g[i], m_b[i]}) begin
                if (bad == 0) begin
                    first_act = {pix_red, pix_grn, pix_blu};
                    first_exp = {m_r[i], m_g[i], m_b[i]};
                end
                bad++;
            end
        end
        check(bad == 0, req, "table sweep", {8'd0, first_act}, {8'd0, first_exp});
    endtask

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] old_v;
        void'($urandom(32'd12345));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(upd_valid == 1'b0, "R1", "upd_valid after reset", {31'd0, upd_valid}, 32'd0);
        sweep("R1");

        // First data write after reset: red of entry 0.
        access(1'b1, 4'd4, 32'h1100_0000, 4'hF, "R1");
        // Index load then full RGB walk.
        access(1'b1, 4'd0, 32'h0500_ABCD, 4'hF, "R2");
        access(1'b1, 4'd4, 32'h2A00_0000, 4'hF, "R3");
        access(1'b1, 4'd4, 32'h3B00_00FF, 4'hF, "R3");
        access(1'b1, 4'd4, 32'h4C12_3456, 4'hF, "R3");
        access(1'b1, 4'd4, 32'h5D00_0000, 4'hF, "R4");
        // Wrap from 255 to 0.
        access(1'b1, 4'd0, 32'hFF00_0000, 4'hF, "R4");
        access(1'b1, 4'd4, 32'h0100_0000, 4'hF, "R4");
        access(1'b1, 4'd4, 32'h0200_0000, 4'hF, "R4");
        access(1'b1, 4'd4, 32'h0300_0000, 4'hF, "R4");
        access(1'b1, 4'd4, 32'h0400_0000, 4'hF, "R4");
        // Restart mid-entry.
        access(1'b1, 4'd0, 32'h0A00_0000, 4'hF, "R5");
        access(1'b1, 4'd4, 32'h7700_0000, 4'hF, "R5");
        access(1'b1, 4'd4, 32'h8800_0000, 4'hF, "R5");
        access(1'b1, 4'd0, 32'h0A00_0000, 4'hF, "R5");
        access(1'b1, 4'd4, 32'h9900_0000, 4'hF, "R5");
        // Reads, bad offsets, partial enables.
        access(1'b0, 4'd4, 32'hFFFF_FFFF, 4'hF, "R6");
        access(1'b0, 4'd0, 32'h0, 4'hF, "R6");
        access(1'b1, 4'd8, 32'hEE00_0000, 4'hF, "R7");
        access(1'b1, 4'd12, 32'hEE00_0000, 4'hF, "R7");
        access(1'b1, 4'd5, 32'hEE00_0000, 4'hF, "R7");
        access(1'b1, 4'd4, 32'hEE00_0000, 4'h7, "R8");
        access(1'b1, 4'd0, 32'h2000_0000, 4'hE, "R8");
        access(1'b1, 4'd4, 32'h6600_0000, 4'hF, "R9");
        sweep("R7");

        // Same-cycle lookup and write of one entry.
        access(1'b1, 4'd0, 32'h3000_0000, 4'hF, "R10");
        old_v = m_r[8'h30];
        @(negedge clk);
        pix_idx = 8'h30;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 4'd4; bus_be = 4'hF;
        bus_wdata = 32'hC300_0000;
        @(posedge clk);
        #1;
        bus_valid = 1'b0;
        m_r[8'h30] = 8'hC3;
        m_ph = 2'd1;
        check(pix_red == old_v, "R10", "lookup during write", {24'd0, pix_red}, {24'd0, old_v});
        @(posedge clk);
        #1;
        check(pix_red == 8'hC3, "R10", "lookup after write", {24'd0, pix_red}, 32'hC3);

        // Random mix with the lookup port busy.
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [3:0] a;
            logic [3:0] be;
            logic [31:0] d;
            op = $urandom_range(0, 7);
            d  = $urandom();
            a  = 4'd4;
            be = 4'hF;
            pix_idx = 8'($urandom());
            case (op)
                0: a = 4'd0;
                5: a = 4'($urandom_range(0, 15));
                6: be = 4'($urandom_range(0, 14));
                default: ;
            endcase
            access(op != 7, a, d, be, "R9");
        end
        sweep("R3");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule